// File: doc/BRIEF.md
# Clock Output Mode and Gating Controller

This block stands between the internal clock generators of a clock synthesizer and its bank of named clock outputs. Every source arrives as a level waveform that is generated in the domain of one system clock, and every output is a registered copy of its selected source, so each output edge is aligned to the system clock. A per-output disable bit stops an output cleanly and holds it actively low. A 2-bit mode field selects one of four global behaviours: normal operation with the spread-spectrum flag cleared, normal operation with the flag set, a bypass test mode in which each output is a fixed division of the reference input, and a mode in which no output is driven.

The block also decides whether the frequency code comes from the two external select pins or from a 4-bit register field. It produces that code and the spread-on flag for the synthesizer, which lies outside this block. Writes to the mode, source and select fields are staged in a shadow register. They take effect together only at the first synchronisation pulse after the write, and every output is held low for one cycle when they do. Writes to the disable bits act at once.

The outputs are indexed as follows. The CPU outputs come first, then the PCI outputs, then the reference copies, then the 48 MHz output at index N_OUT-2, and finally the 24 MHz output at index N_OUT-1. With the default parameters these are 2 CPU, 7 PCI and 2 reference outputs, which gives 13 in total.

Top module: `clk_out_ctrl`

## Requirements
- R1: After reset the active mode is 2'b10 and the frequency source is the pins. All outputs are enabled and driven, so `clk_oe_o` is all ones, `spread_on_o` is 1 and `freq_code_o` is {1'b0, 2'b00, fs_pins_i}.
- R2: The mode encoding is 00 for spread off, 01 for bypass test, 10 for spread on and 11 for all outputs undriven. `spread_on_o` is 1 exactly one cycle after the active mode is 10, and 0 one cycle after any other active mode.
- R3: In modes 00 and 10, each enabled output equals its source one cycle later. CPU outputs follow `src_cpu_i`, PCI outputs follow `src_pci_i`, reference copies follow `ref_i`, the 48 MHz output follows `src_48_i` and the 24 MHz output follows `src_24_i`.
- R4: In mode 01 a half-rate signal toggles on every rising edge of `ref_i`, and a quarter-rate signal toggles on every second rising edge. CPU and 48 MHz outputs take the half-rate signal, PCI and 24 MHz outputs take the quarter-rate signal, and reference copies take `ref_i`. Both dividers start at 0 after reset.
- R5: In mode 11, `clk_oe_o` is all zeros and `clk_o` is all zeros one cycle later, whatever the disable bits or the previous mode.
- R6: An output whose gate is closed is driven low and its `clk_oe_o` bit stays 1 (outside mode 11).
- R7: An output's gate opens or closes only on a cycle in which that output's selected source is low. A high pulse on an output is therefore always a complete copy of the source pulse.
- R8: `freq_code_o` is {1'b1, fsel} when the active frequency source bit is 1, and {1'b0, 2'b00, fs_pins_i} when it is 0. It is registered one cycle after the active settings.
- R9: A write to mode, source or select is applied on the first `sync_i` cycle strictly after the write cycle. A write that coincides with `sync_i` waits for the next pulse.
- R10: In the cycle after the staged settings are applied, every bit of `clk_o` is 0.
- R11: The disable bits (bit i controls output i, where 1 means disable) are taken from every write without waiting for `sync_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_cpu_i | input | 1 | CPU clock source waveform |
| src_pci_i | input | 1 | PCI clock source waveform |
| src_48_i | input | 1 | 48 MHz source waveform |
| src_24_i | input | 1 | 24 MHz source waveform |
| ref_i | input | 1 | Reference waveform |
| fs_pins_i | input | 2 | External frequency select pins |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_mode_i | input | 2 | Mode field |
| cfg_fsrc_i | input | 1 | Frequency source: 0 pins, 1 register |
| cfg_fsel_i | input | 4 | Register frequency select |
| cfg_dis_i | input | N_OUT | Per-output disable bits |
| sync_i | input | 1 | Synchronisation point for staged settings |
| clk_o | output | N_OUT | Clock outputs |
| clk_oe_o | output | N_OUT | Output drive enables |
| spread_on_o | output | 1 | Spread modulation request |
| freq_code_o | output | 5 | Selected frequency code |

## Verification
A register write and a synchronisation pulse can arrive in the same cycle. When that happens, the block must apply the settings staged earlier and keep the new ones pending. The bench provokes this by raising `cfg_wr_i` and `sync_i` together. It then confirms that `freq_code_o` keeps its old value until a later pulse, and that the one-cycle low hold appears only when the new settings are actually applied. A disable write that lands while the source of that output is high is also swept over every output and every phase. Each case is judged against a cycle model of the gating rules.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

    localparam int FSEL_W = 4;
    localparam int CODE_W = FSEL_W + 1;

    typedef enum logic [1:0] {
        MODE_SPREAD_OFF = 2'b00,
        MODE_TEST       = 2'b01,
        MODE_SPREAD_ON  = 2'b10,
        MODE_HIZ        = 2'b11
    } ckg_mode_e;

    typedef enum logic [2:0] {
        CLS_CPU,
        CLS_PCI,
        CLS_REF,
        CLS_48,
        CLS_24
    } ckg_class_e;

    typedef struct packed {
        ckg_mode_e         mode;
        logic              fsrc;
        logic [FSEL_W-1:0] fsel;
    } ckg_ctl_t;

    localparam ckg_ctl_t CTL_DEFAULT = '{mode: MODE_SPREAD_ON, fsrc: 1'b0, fsel: '0};

    function automatic ckg_class_e class_of(input int idx, input int n_cpu,
                                            input int n_pci, input int n_ref);
        if (idx < n_cpu)                       return CLS_CPU;
        else if (idx < n_cpu + n_pci)          return CLS_PCI;
        else if (idx < n_cpu + n_pci + n_ref)  return CLS_REF;
        else if (idx == n_cpu + n_pci + n_ref) return CLS_48;
        else                                   return CLS_24;
    endfunction

endpackage

// File: rtl/ckg_mode_ctl.sv
module ckg_mode_ctl
    import ckg_pkg::*;
#(
    parameter int N_OUT = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  ckg_ctl_t          cfg_ctl,
    input  logic [N_OUT-1:0]  cfg_dis,
    input  logic              sync,
    input  logic [1:0]        fs_pins,
    output ckg_ctl_t          act,
    output logic              hold,
    output logic [N_OUT-1:0]  dis,
    output logic              spread,
    output logic [CODE_W-1:0] code
);

    ckg_ctl_t shadow_q;
    ckg_ctl_t act_q;
    logic     pending_q;
    logic     apply;

    assign apply = sync & pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q  <= CTL_DEFAULT;
            act_q     <= CTL_DEFAULT;
            pending_q <= 1'b0;
            hold      <= 1'b0;
            dis       <= '0;
            spread    <= 1'b1;
            code      <= '0;
        end else begin
            if (cfg_wr) begin
                shadow_q <= cfg_ctl;
                dis      <= cfg_dis;
            end
            pending_q <= cfg_wr | (pending_q & ~sync);
            if (apply) act_q <= shadow_q;
            hold   <= apply;
            spread <= (act_q.mode == MODE_SPREAD_ON);
            code   <= act_q.fsrc ? {1'b1, act_q.fsel}
                                 : {1'b0, {(FSEL_W-2){1'b0}}, fs_pins};
        end
    end

    assign act = act_q;

endmodule

// File: rtl/ckg_test_div.sv
module ckg_test_div (
    input  logic clk,
    input  logic rst,
    input  logic ref_lvl,
    output logic half,
    output logic quarter
);

    logic ref_d;
    logic rise;

    assign rise = ref_lvl & ~ref_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_d   <= 1'b0;
            half    <= 1'b0;
            quarter <= 1'b0;
        end else begin
            ref_d <= ref_lvl;
            if (rise) begin
                half <= ~half;
                if (half) quarter <= ~quarter;
            end
        end
    end

endmodule

// File: rtl/ckg_out_gate.sv
module ckg_out_gate (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic dis,
    input  logic hold,
    input  logic hiz,
    output logic out,
    output logic oe,
    output logic en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= 1'b1;
            out <= 1'b0;
            oe  <= 1'b1;
        end else begin
            if (!src) en <= ~dis;
            out <= (hold | hiz) ? 1'b0 : (src & en);
            oe  <= ~hiz;
        end
    end

endmodule

// File: rtl/clk_out_ctrl.sv
module clk_out_ctrl
    import ckg_pkg::*;
#(
    parameter int N_CPU = 2,
    parameter int N_PCI = 7,
    parameter int N_REF = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           src_cpu_i,
    input  logic                           src_pci_i,
    input  logic                           src_48_i,
    input  logic                           src_24_i,
    input  logic                           ref_i,
    input  logic [1:0]                     fs_pins_i,
    input  logic                           cfg_wr_i,
    input  logic [1:0]                     cfg_mode_i,
    input  logic                           cfg_fsrc_i,
    input  logic [3:0]                     cfg_fsel_i,
    input  logic [N_CPU+N_PCI+N_REF+1:0]   cfg_dis_i,
    input  logic                           sync_i,
    output logic [N_CPU+N_PCI+N_REF+1:0]   clk_o,
    output logic [N_CPU+N_PCI+N_REF+1:0]   clk_oe_o,
    output logic                           spread_on_o,
    output logic [4:0]                     freq_code_o
);

    localparam int N_OUT = N_CPU + N_PCI + N_REF + 2;

    ckg_ctl_t          cfg_ctl;
    ckg_ctl_t          act_ctl;
    logic              hold_w;
    logic [N_OUT-1:0]  dis_w;
    logic              half_w;
    logic              quarter_w;
    logic              test_w;
    logic              hiz_w;
    logic [1:0]        act_mode_w;
    logic [N_OUT-1:0]  sel_src;
    logic [N_OUT-1:0]  en_vec;

    assign cfg_ctl = '{mode: ckg_mode_e'(cfg_mode_i), fsrc: cfg_fsrc_i, fsel: cfg_fsel_i};

    ckg_mode_ctl #(.N_OUT(N_OUT)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .cfg_wr  (cfg_wr_i),
        .cfg_ctl (cfg_ctl),
        .cfg_dis (cfg_dis_i),
        .sync    (sync_i),
        .fs_pins (fs_pins_i),
        .act     (act_ctl),
        .hold    (hold_w),
        .dis     (dis_w),
        .spread  (spread_on_o),
        .code    (freq_code_o)
    );

    ckg_test_div u_div (
        .clk     (clk),
        .rst     (rst),
        .ref_lvl (ref_i),
        .half    (half_w),
        .quarter (quarter_w)
    );

    assign act_mode_w = act_ctl.mode;
    assign test_w     = (act_ctl.mode == MODE_TEST);
    assign hiz_w      = (act_ctl.mode == MODE_HIZ);

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        localparam ckg_class_e CLS = class_of(i, N_CPU, N_PCI, N_REF);

        always_comb begin
            case (CLS)
                CLS_CPU: sel_src[i] = test_w ? half_w    : src_cpu_i;
                CLS_PCI: sel_src[i] = test_w ? quarter_w : src_pci_i;
                CLS_48:  sel_src[i] = test_w ? half_w    : src_48_i;
                CLS_24:  sel_src[i] = test_w ? quarter_w : src_24_i;
                default: sel_src[i] = ref_i;
            endcase
        end

        ckg_out_gate u_gate (
            .clk  (clk),
            .rst  (rst),
            .src  (sel_src[i]),
            .dis  (dis_w[i]),
            .hold (hold_w),
            .hiz  (hiz_w),
            .out  (clk_o[i]),
            .oe   (clk_oe_o[i]),
            .en   (en_vec[i])
        );
    end

endmodule

// File: rtl/ckg_chk.sv
module ckg_chk #(
    parameter int N_OUT = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             sync_i,
    input logic [1:0]       act_mode,
    input logic             hold,
    input logic             hiz,
    input logic             spread_o,
    input logic [N_OUT-1:0] out,
    input logic [N_OUT-1:0] oe,
    input logic [N_OUT-1:0] en_vec,
    input logic [N_OUT-1:0] sel_src
);

    // R5
    hiz_oe_chk: assert property (@(posedge clk) disable iff (rst)
        hiz |=> (oe == '0));

    // R10
    hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> (out == '0));

    // R9
    apply_sync_chk: assert property (@(posedge clk) disable iff (rst)
        !sync_i |=> $stable(act_mode));

    // R2
    spread_on_chk: assert property (@(posedge clk) disable iff (rst)
        (act_mode == 2'b10) |=> spread_o);

    // R2
    spread_off_chk: assert property (@(posedge clk) disable iff (rst)
        (act_mode != 2'b10) |=> !spread_o);

    for (genvar i = 0; i < N_OUT; i++) begin : g_chk
        // R6
        dis_low_chk: assert property (@(posedge clk) disable iff (rst)
            !en_vec[i] |=> !out[i]);

        // R7
        gate_stable_chk: assert property (@(posedge clk) disable iff (rst)
            sel_src[i] |=> $stable(en_vec[i]));
    end

endmodule

bind clk_out_ctrl ckg_chk #(.N_OUT(N_CPU + N_PCI + N_REF + 2)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sync_i   (sync_i),
    .act_mode (act_mode_w),
    .hold     (hold_w),
    .hiz      (hiz_w),
    .spread_o (spread_on_o),
    .out      (clk_o),
    .oe       (clk_oe_o),
    .en_vec   (en_vec),
    .sel_src  (sel_src)
);

// File: tb/sim_clk_out_ctrl.sv
module sim_clk_out_ctrl;

    localparam int NC = 2;
    localparam int NP = 7;
    localparam int NR = 2;
    localparam int NO = NC + NP + NR + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [7:0]    tcnt = '0;
    logic          src_cpu, src_pci, src_48, src_24, ref_w;
    logic [1:0]    fs = 2'b00;
    logic          wr = 1'b0;
    logic [1:0]    mode = 2'b10;
    logic          fsrc = 1'b0;
    logic [3:0]    fsel = '0;
    logic [NO-1:0] dis = '0;
    logic          sync = 1'b0;
    logic [NO-1:0] clk_o, oe_o;
    logic          spread_o;
    logic [4:0]    code_o;

    assign src_cpu = tcnt[0];
    assign src_pci = tcnt[3];
    assign src_48  = tcnt[0] ^ tcnt[2];
    assign src_24  = tcnt[2];
    assign ref_w   = tcnt[1];

    always @(negedge clk) tcnt <= tcnt + 8'd1;

    clk_out_ctrl #(.N_CPU(NC), .N_PCI(NP), .N_REF(NR)) u0 (
        .clk(clk), .rst(rst),
        .src_cpu_i(src_cpu), .src_pci_i(src_pci), .src_48_i(src_48),
        .src_24_i(src_24), .ref_i(ref_w), .fs_pins_i(fs),
        .cfg_wr_i(wr), .cfg_mode_i(mode), .cfg_fsrc_i(fsrc), .cfg_fsel_i(fsel),
        .cfg_dis_i(dis), .sync_i(sync),
        .clk_o(clk_o), .clk_oe_o(oe_o), .spread_on_o(spread_o), .freq_code_o(code_o)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    logic  chk_on = 1'b0;

    // cycle model built from the requirements
    logic [1:0]    m_sh_mode, m_mode;
    logic          m_sh_fsrc, m_fsrc, m_pend, m_hold, m_spread;
    logic [3:0]    m_sh_fsel, m_fsel;
    logic [NO-1:0] m_dis, m_en, m_out, m_oe;
    logic          m_refd, m_d2, m_d4;
    logic [4:0]    m_code;

    function automatic logic msel(input int i);
        logic t;
        t = (m_mode == 2'b01);
        if (i < NC)                return t ? m_d2 : src_cpu;
        else if (i < NC + NP)      return t ? m_d4 : src_pci;
        else if (i < NC + NP + NR) return ref_w;
        else if (i == NO - 2)      return t ? m_d2 : src_48;
        else                       return t ? m_d4 : src_24;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sh_mode <= 2'b10; m_mode <= 2'b10;
            m_sh_fsrc <= 1'b0;  m_fsrc <= 1'b0;
            m_sh_fsel <= '0;    m_fsel <= '0;
            m_pend <= 1'b0; m_hold <= 1'b0; m_spread <= 1'b1; m_code <= '0;
            m_dis <= '0; m_en <= '1; m_out <= '0; m_oe <= '1;
            m_refd <= 1'b0; m_d2 <= 1'b0; m_d4 <= 1'b0;
        end else begin
            if (wr) begin
                m_sh_mode <= mode; m_sh_fsrc <= fsrc; m_sh_fsel <= fsel; m_dis <= dis;
            end
            m_pend <= wr | (m_pend & ~sync);
            if (sync && m_pend) begin
                m_mode <= m_sh_mode; m_fsrc <= m_sh_fsrc; m_fsel <= m_sh_fsel;
            end
            m_hold   <= sync & m_pend;
            m_spread <= (m_mode == 2'b10);
            m_code   <= m_fsrc ? {1'b1, m_fsel} : {3'b000, fs};
            m_refd   <= ref_w;
            if (ref_w && !m_refd) begin
                m_d2 <= ~m_d2;
                if (m_d2) m_d4 <= ~m_d4;
            end
            for (int i = 0; i < NO; i++) begin
                if (!msel(i)) m_en[i] <= ~m_dis[i];
                m_out[i] <= (m_hold || m_mode == 2'b11) ? 1'b0 : (msel(i) & m_en[i]);
                m_oe[i]  <= (m_mode != 2'b11);
            end
        end
    end

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !rst) begin
            cmp("clk_o", 32'(clk_o), 32'(m_out));
            cmp("clk_oe_o", 32'(oe_o), 32'(m_oe));
            cmp("spread_on_o", 32'(spread_o), 32'(m_spread));
            cmp("freq_code_o", 32'(code_o), 32'(m_code));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [1:0] md, input logic fr, input logic [3:0] fl,
                          input logic [NO-1:0] d, input logic with_sync);
        mode = md; fsrc = fr; fsel = fl; dis = d; wr = 1'b1; sync = with_sync;
        cyc(1);
        wr = 1'b0; sync = 1'b0;
    endtask

    task automatic do_sync();
        sync = 1'b1;
        cyc(1);
        sync = 1'b0;
        cyc(1);
        cmp("clk_o during hold R10", 32'(clk_o), 32'd0);
    endtask

    logic done = 1'b0;

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(2);
        // R1 reset state
        cmp("spread_on_o reset", 32'(spread_o), 32'd1);
        cmp("clk_oe_o reset", 32'(oe_o), 32'(NO'('1)));
        cmp("freq_code_o reset", 32'(code_o), 32'd0);
        chk_on = 1'b1;

        // R3 and R8: normal spread-on mode under every pin value
        cur_req = "R3/R8";
        for (int p = 0; p < 4; p++) begin
            fs = 2'(p);
            cyc(20);
            cmp("freq_code_o pins R8", 32'(code_o), 32'(p));
        end

        // R9: staged write waits for sync
        cur_req = "R9";
        wr_cfg(2'b00, 1'b0, 4'd0, '0, 1'b0);
        cyc(5);
        cmp("spread_on_o before sync", 32'(spread_o), 32'd1);
        cur_req = "R10";
        do_sync();
        cyc(1);
        cur_req = "R2";
        cmp("spread_on_o after apply", 32'(spread_o), 32'd0);

        // R9: write in the same cycle as sync stays pending
        cur_req = "R9";
        wr_cfg(2'b00, 1'b1, 4'd5, '0, 1'b1);
        cyc(4);
        cmp("freq_code_o same-cycle write", 32'(code_o), 32'(fs));
        do_sync();
        cyc(1);
        cur_req = "R8";
        cmp("freq_code_o register", 32'(code_o), 32'h15);

        // R8: every register select value
        for (int f = 0; f < 16; f++) begin
            wr_cfg(2'b00, 1'b1, 4'(f), '0, 1'b0);
            do_sync();
            cyc(2);
            cmp("freq_code_o sweep", 32'(code_o), 32'(16 + f));
        end

        // R4 bypass test mode
        cur_req = "R4";
        wr_cfg(2'b01, 1'b0, 4'd0, '0, 1'b0);
        do_sync();
        cyc(80);

        // R6 and R11: disables act without sync
        cur_req = "R11";
        wr_cfg(2'b01, 1'b0, 4'd0, '1, 1'b0);
        cyc(20);
        cmp("clk_o all disabled R6", 32'(clk_o), 32'd0);
        cmp("clk_oe_o disabled R6", 32'(oe_o), 32'(NO'('1)));
        wr_cfg(2'b00, 1'b0, 4'd0, '0, 1'b0);
        do_sync();
        cyc(20);

        // R7: single disables at every phase on every output
        cur_req = "R7";
        for (int k = 0; k < NO; k++) begin
            for (int ph = 0; ph < 4; ph++) begin
                cyc(ph);
                wr_cfg(2'b00, 1'b0, 4'd0, NO'(1) << k, 1'b0);
                cyc(10);
                wr_cfg(2'b00, 1'b0, 4'd0, '0, 1'b0);
                cyc(10);
            end
        end

        // R5: all outputs undriven with disables and from test mode
        cur_req = "R5";
        wr_cfg(2'b01, 1'b0, 4'd0, NO'(13'h0a5a), 1'b0);
        do_sync();
        cyc(10);
        wr_cfg(2'b11, 1'b0, 4'd0, NO'(13'h0a5a), 1'b0);
        do_sync();
        cyc(10);
        cmp("clk_oe_o in mode 11", 32'(oe_o), 32'd0);
        cmp("clk_o in mode 11", 32'(clk_o), 32'd0);

        // R2: sweep of all modes and sources
        cur_req = "R2";
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                wr_cfg(2'(m), 1'(s), 4'(m * 3 + s), '0, 1'b0);
                cyc(s * 3);
                do_sync();
                cyc(24);
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule